// File: doc/BRIEF.md
# Interleaved Two-Bank Page-Mode DRAM Sequencer

This block sits between a processor's local bus and a pair of 32-bit page-mode DRAM banks. It turns each access request into a row strobe, a column strobe and a write-enable sequence, and it drives a multiplexed row/column address bus for each bank. It also drives the latch and transmit enables of the external buffers that join the memory to the processor's data bus and instruction bus.

Even word addresses live in the first bank and odd word addresses live in the second. Every access opens the same row in both banks. A request can then be stretched into a burst by holding the burst input high. The column strobe then moves from one bank to the other on every clock, so that a word is ready on each clock. A configuration input chooses a short or a long simple-access latency. The sequencer always leaves two clocks with both row strobes high before it opens another row. A request that arrives while an access is in progress is held and started as soon as that precharge window ends.

Top module: `burst_dram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `rdy` is 0. All strobe and enable outputs are inactive: `ras_n_*` = 1, `cas_n_*` = 4'hF, `we_n_*` = 1, `wr_latch_*` = 0, `dbus_oe_n_*` = 1 and `ibus_oe_n_*` = 1.
- R2: With `cfg_fast` = 1, a request sampled in cycle 0 yields the column strobe in cycle 3 and a single `rdy` pulse in cycle 4.
- R3: With `cfg_fast` = 0, one extra clock is inserted before the column strobe: column strobe in cycle 4, `rdy` in cycle 5.
- R4: The row strobes are low from cycle 1 through the last column-strobe cycle, and high in the `rdy` cycle that ends the access. After any rising edge of a row strobe, it stays high for at least 2 clocks. Back-to-back requests therefore produce `rdy` pulses 5 clocks apart (fast) or 6 clocks apart (slow).
- R5: A request that arrives while an access is in progress is captured with its address and attributes. Its row phase starts in the clock after the precharge window, and its column strobe then uses the captured byte lanes and bank.
- R6: Bit 0 of the word address selects the bank: 0 selects bank A, 1 selects bank B. A word's column strobe goes only to its bank, with `cas_n` = ~`req_be`, so bit i of the strobe bus belongs to byte lane i.
- R7: If `burst_req` is high in a column-strobe cycle, the next clock strobes the next word address in the other bank, and `rdy` is high in that clock as well. This gives one `rdy` per clock, strictly alternating bank strobes and a column that advances every two words. A burst of N words ends with `rdy` in cycle S+N, where S is the first column-strobe cycle.
- R8: The address bus of each bank carries the row, word-address bits [2*MA_W:MA_W+1], in cycle 1. It carries the column, word-address bits [MA_W:1], in every cycle in which that bank's column strobe is low. In the request cycle the row reaches both buses combinationally.
- R9: For a write, both write enables are low together while the row strobes are low. `wr_latch_*` of a bank is high exactly in that bank's column-strobe cycles.
- R10: For a read, in the `rdy` cycle of each word, the transmit enable of that word's bank is driven low. This is `ibus_oe_n_*` when `req_instr` was 1 and `dbus_oe_n_*` otherwise. The other enables stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fast | input | 1 | 1 selects the short simple-access latency |
| req | input | 1 | Access request, one clock per access |
| req_wr | input | 1 | Request is a write |
| req_instr | input | 1 | Request is an instruction fetch |
| req_be | input | 4 | Byte lanes of the request |
| req_addr | input | 2*MA_W+1 | Word address of the request |
| burst_req | input | 1 | Extend the access by one word (sampled in column-strobe cycles) |
| rdy | output | 1 | Word ready / accepted |
| ma_a | output | MA_W | Multiplexed address, bank A |
| ma_b | output | MA_W | Multiplexed address, bank B |
| ras_n_a | output | 1 | Row strobe, bank A, active low |
| ras_n_b | output | 1 | Row strobe, bank B, active low |
| cas_n_a | output | 4 | Per-lane column strobes, bank A, active low |
| cas_n_b | output | 4 | Per-lane column strobes, bank B, active low |
| we_n_a | output | 1 | Write enable, bank A, active low |
| we_n_b | output | 1 | Write enable, bank B, active low |
| wr_latch_a | output | 1 | Write data latch enable, bank A |
| wr_latch_b | output | 1 | Write data latch enable, bank B |
| dbus_oe_n_a | output | 1 | Bank A to data bus transmit enable, active low |
| dbus_oe_n_b | output | 1 | Bank B to data bus transmit enable, active low |
| ibus_oe_n_a | output | 1 | Bank A to instruction bus transmit enable, active low |
| ibus_oe_n_b | output | 1 | Bank B to instruction bus transmit enable, active low |

## Verification
The assertions assume that at most one request is waiting behind the access in progress, and that `cfg_fast` does not change while an access runs. They also assume that `burst_req` is only meaningful in column-strobe cycles. The stimulus issues a new request only when the sequencer has returned to idle, except in the back-to-back cases, which add exactly one request in the clock after the first. It holds `cfg_fast` for the whole access and raises `burst_req` only in the strobe cycles of the burst length it has drawn.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_WAIT, ST_STRB, ST_BST, ST_DONE, ST_PRE
  } state_e;

  typedef struct packed {
    logic             wr;
    logic             instr;
    logic [LANES-1:0] be;
  } attr_t;

  function automatic logic row_open(state_e s);
    return (s == ST_ROW) || (s == ST_COL) || (s == ST_WAIT) ||
           (s == ST_STRB) || (s == ST_BST);
  endfunction

  function automatic logic col_strobe(state_e s);
    return (s == ST_STRB) || (s == ST_BST);
  endfunction
endpackage

// File: rtl/bdc_seq.sv
module bdc_seq
  import bdc_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_instr,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              burst_req,
  output state_e            state_q,
  output state_e            state_nxt,
  output logic              bank_q,
  output logic              bank_nxt,
  output attr_t             attr_q,
  output attr_t             attr_nxt,
  output logic              start_live,
  output logic              start_any,
  output logic [ADDR_W-1:0] start_addr
);
  logic              pend_q;
  attr_t             pend_attr_q;
  logic [ADDR_W-1:0] pend_addr_q;
  attr_t             live_attr;
  attr_t             start_attr;
  logic              accept_ok;
  logic              start_pend;

  assign live_attr  = '{wr: req_wr, instr: req_instr, be: req_be};
  assign accept_ok  = (state_q == ST_IDLE) || (state_q == ST_PRE);
  assign start_live = req && accept_ok && !pend_q;
  assign start_pend = pend_q && accept_ok;
  assign start_any  = start_live || start_pend;
  assign start_addr = start_pend ? pend_addr_q : req_addr;
  assign start_attr = start_pend ? pend_attr_q : live_attr;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE, ST_PRE: state_nxt = start_any ? ST_ROW : ST_IDLE;
      ST_ROW:          state_nxt = ST_COL;
      ST_COL:          state_nxt = cfg_fast ? ST_STRB : ST_WAIT;
      ST_WAIT:         state_nxt = ST_STRB;
      ST_STRB, ST_BST: state_nxt = burst_req ? ST_BST : ST_DONE;
      ST_DONE:         state_nxt = ST_PRE;
      default:         state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (start_any)              bank_nxt = start_addr[0];
    else if (state_nxt == ST_BST) bank_nxt = ~bank_q;
    else                        bank_nxt = bank_q;
  end

  assign attr_nxt = start_any ? start_attr : attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bank_q  <= 1'b0;
      attr_q  <= '0;
    end else begin
      state_q <= state_nxt;
      bank_q  <= bank_nxt;
      attr_q  <= attr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_attr_q <= '0;
      pend_addr_q <= '0;
    end else if (req && !start_live) begin
      pend_q      <= 1'b1;
      pend_attr_q <= live_attr;
      pend_addr_q <= req_addr;
    end else if (start_pend) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bdc_addr.sv
module bdc_addr
  import bdc_pkg::*;
#(
  parameter int MA_W = 11,
  localparam int ADDR_W = 2 * MA_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_any,
  input  logic                 start_live,
  input  logic [ADDR_W-1:0]    start_addr,
  input  state_e               state_q,
  input  logic                 bank_q,
  output logic [1:0][MA_W-1:0] ma
);
  function automatic logic [MA_W-1:0] row_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: MA_W];
  endfunction

  function automatic logic [MA_W-1:0] col_of(logic [ADDR_W-1:0] a);
    return a[MA_W:1];
  endfunction

  // Column of the first word this bank serves when an access starts at a.
  function automatic logic [MA_W-1:0] first_col(logic [ADDR_W-1:0] a, int bank);
    return col_of(a) + MA_W'((bank == 0 && a[0]) ? 1 : 0);
  endfunction

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [MA_W-1:0] col_q;
    logic [MA_W-1:0] ma_q;
    logic            hit_q;

    assign hit_q = col_strobe(state_q) && (bank_q == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        col_q <= '0;
        ma_q  <= '0;
      end else if (start_any) begin
        col_q <= first_col(start_addr, b);
        ma_q  <= row_of(start_addr);
      end else if (state_q == ST_ROW) begin
        ma_q <= col_q;
      end else if (hit_q) begin
        ma_q <= ma_q + 1'b1;
      end
    end

    // Only combinational route to the pins: row of the request being accepted.
    assign ma[b] = start_live ? row_of(start_addr) : ma_q;
  end
endmodule

// File: rtl/bdc_strobe.sv
module bdc_strobe
  import bdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  state_e                state_q,
  input  state_e                state_nxt,
  input  logic                  bank_q,
  input  logic                  bank_nxt,
  input  attr_t                 attr_q,
  input  attr_t                 attr_nxt,
  output logic                  rdy,
  output logic [1:0]            ras_n,
  output logic [1:0][LANES-1:0] cas_n,
  output logic [1:0]            we_n,
  output logic [1:0]            wr_latch,
  output logic [1:0]            dbus_oe_n,
  output logic [1:0]            ibus_oe_n
);
  logic ras_on_nxt;
  logic cas_on_nxt;
  logic cas_on_q;

  assign ras_on_nxt = row_open(state_nxt);
  assign cas_on_nxt = col_strobe(state_nxt);
  assign cas_on_q   = col_strobe(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy <= 1'b0;
    else        rdy <= cas_on_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic sel_nxt;
    logic sel_q;
    assign sel_nxt = cas_on_nxt && (bank_nxt == 1'(b));
    assign sel_q   = cas_on_q && (bank_q == 1'(b)) && !attr_q.wr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ras_n[b]     <= 1'b1;
        cas_n[b]     <= '1;
        we_n[b]      <= 1'b1;
        wr_latch[b]  <= 1'b0;
        dbus_oe_n[b] <= 1'b1;
        ibus_oe_n[b] <= 1'b1;
      end else begin
        ras_n[b]     <= !ras_on_nxt;
        cas_n[b]     <= sel_nxt ? ~attr_nxt.be : '1;
        we_n[b]      <= !(ras_on_nxt && attr_nxt.wr);
        wr_latch[b]  <= sel_nxt && attr_nxt.wr;
        dbus_oe_n[b] <= !(sel_q && !attr_q.instr);
        ibus_oe_n[b] <= !(sel_q && attr_q.instr);
      end
    end
  end
endmodule

// File: rtl/burst_dram_ctrl.sv
module burst_dram_ctrl
  import bdc_pkg::*;
#(
  parameter int MA_W = 11,
  localparam int ADDR_W = 2 * MA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_instr,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              burst_req,
  output logic              rdy,
  output logic [MA_W-1:0]   ma_a,
  output logic [MA_W-1:0]   ma_b,
  output logic              ras_n_a,
  output logic              ras_n_b,
  output logic [LANES-1:0]  cas_n_a,
  output logic [LANES-1:0]  cas_n_b,
  output logic              we_n_a,
  output logic              we_n_b,
  output logic              wr_latch_a,
  output logic              wr_latch_b,
  output logic              dbus_oe_n_a,
  output logic              dbus_oe_n_b,
  output logic              ibus_oe_n_a,
  output logic              ibus_oe_n_b
);
  state_e                state_q, state_nxt;
  logic                  bank_q, bank_nxt;
  attr_t                 attr_q, attr_nxt;
  logic                  start_live, start_any;
  logic [ADDR_W-1:0]     start_addr;
  logic [1:0][MA_W-1:0]  ma;
  logic [1:0]            ras_n, we_n, wr_latch, dbus_oe_n, ibus_oe_n;
  logic [1:0][LANES-1:0] cas_n;

  // Named events for the checker.
  logic cas_act_a, cas_act_b;
  assign cas_act_a = (cas_n_a != '1);
  assign cas_act_b = (cas_n_b != '1);

  bdc_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .req(req),
    .req_wr(req_wr), .req_instr(req_instr), .req_be(req_be),
    .req_addr(req_addr), .burst_req(burst_req),
    .state_q(state_q), .state_nxt(state_nxt), .bank_q(bank_q),
    .bank_nxt(bank_nxt), .attr_q(attr_q), .attr_nxt(attr_nxt),
    .start_live(start_live), .start_any(start_any), .start_addr(start_addr)
  );

  bdc_addr #(.MA_W(MA_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .start_any(start_any), .start_live(start_live),
    .start_addr(start_addr), .state_q(state_q), .bank_q(bank_q), .ma(ma)
  );

  bdc_strobe strobe_i (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_nxt(state_nxt),
    .bank_q(bank_q), .bank_nxt(bank_nxt), .attr_q(attr_q), .attr_nxt(attr_nxt),
    .rdy(rdy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .wr_latch(wr_latch), .dbus_oe_n(dbus_oe_n), .ibus_oe_n(ibus_oe_n)
  );

  assign ma_a        = ma[0];
  assign ma_b        = ma[1];
  assign ras_n_a     = ras_n[0];
  assign ras_n_b     = ras_n[1];
  assign cas_n_a     = cas_n[0];
  assign cas_n_b     = cas_n[1];
  assign we_n_a      = we_n[0];
  assign we_n_b      = we_n[1];
  assign wr_latch_a  = wr_latch[0];
  assign wr_latch_b  = wr_latch[1];
  assign dbus_oe_n_a = dbus_oe_n[0];
  assign dbus_oe_n_b = dbus_oe_n[1];
  assign ibus_oe_n_a = ibus_oe_n[0];
  assign ibus_oe_n_b = ibus_oe_n[1];
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker (
  input logic clk,
  input logic rst_n,
  input logic rdy,
  input logic ras_n_a,
  input logic ras_n_b,
  input logic cas_act_a,
  input logic cas_act_b,
  input logic we_n_a,
  input logic we_n_b,
  input logic wr_latch_a,
  input logic wr_latch_b,
  input logic dbus_oe_n_a,
  input logic dbus_oe_n_b,
  input logic ibus_oe_n_a,
  input logic ibus_oe_n_b
);
  AST_PRECHARGE_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_a) |=> ras_n_a); // R4
  AST_PRECHARGE_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_b) |=> ras_n_b); // R4
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_act_a |-> !ras_n_a) and (cas_act_b |-> !ras_n_b)); // R6
  AST_ONE_BANK_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cas_act_a, cas_act_b})); // R7
  AST_BANK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_act_a |=> !cas_act_a) and (cas_act_b |=> !cas_act_b)); // R7
  AST_RDY_FOLLOWS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> $past(cas_act_a || cas_act_b)); // R2
  AST_WE_TWINS: assert property (@(posedge clk) disable iff (!rst_n)
    we_n_a == we_n_b); // R9
  AST_LATCH_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_latch_a |-> cas_act_a && !we_n_a) and
    (wr_latch_b |-> cas_act_b && !we_n_b)); // R9
  AST_ONE_BUS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~dbus_oe_n_a, ~dbus_oe_n_b, ~ibus_oe_n_a, ~ibus_oe_n_b}) <= 1); // R10
  AST_XMIT_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbus_oe_n_a || !dbus_oe_n_b || !ibus_oe_n_a || !ibus_oe_n_b) |-> rdy); // R10
endmodule

bind burst_dram_ctrl bdc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .rdy(rdy),
  .ras_n_a(ras_n_a), .ras_n_b(ras_n_b),
  .cas_act_a(cas_act_a), .cas_act_b(cas_act_b),
  .we_n_a(we_n_a), .we_n_b(we_n_b),
  .wr_latch_a(wr_latch_a), .wr_latch_b(wr_latch_b),
  .dbus_oe_n_a(dbus_oe_n_a), .dbus_oe_n_b(dbus_oe_n_b),
  .ibus_oe_n_a(ibus_oe_n_a), .ibus_oe_n_b(ibus_oe_n_b)
);

// File: tb/burst_dram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_dram_ctrl_tb_top;
  localparam int MA_W   = 11;
  localparam int ADDR_W = 2 * MA_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fast = 1'b1, req = 1'b0, req_wr = 1'b0, req_instr = 1'b0;
  logic [3:0] req_be = 4'hF;
  logic [ADDR_W-1:0] req_addr = '0;
  logic burst_req = 1'b0;
  logic rdy, ras_n_a, ras_n_b, we_n_a, we_n_b, wr_latch_a, wr_latch_b;
  logic dbus_oe_n_a, dbus_oe_n_b, ibus_oe_n_a, ibus_oe_n_b;
  logic [MA_W-1:0] ma_a, ma_b;
  logic [3:0] cas_n_a, cas_n_b;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  burst_dram_ctrl #(.MA_W(MA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .req(req), .req_wr(req_wr),
    .req_instr(req_instr), .req_be(req_be), .req_addr(req_addr),
    .burst_req(burst_req), .rdy(rdy), .ma_a(ma_a), .ma_b(ma_b),
    .ras_n_a(ras_n_a), .ras_n_b(ras_n_b), .cas_n_a(cas_n_a), .cas_n_b(cas_n_b),
    .we_n_a(we_n_a), .we_n_b(we_n_b), .wr_latch_a(wr_latch_a),
    .wr_latch_b(wr_latch_b), .dbus_oe_n_a(dbus_oe_n_a),
    .dbus_oe_n_b(dbus_oe_n_b), .ibus_oe_n_a(ibus_oe_n_a),
    .ibus_oe_n_b(ibus_oe_n_b)
  );

  // Expected-value helpers restating R2/R3/R6/R8.
  function automatic int strobe_cycle(logic fast);
    return fast ? 3 : 4;
  endfunction
  function automatic logic [MA_W-1:0] exp_row(logic [ADDR_W-1:0] w);
    return MA_W'(w >> (MA_W + 1));
  endfunction
  function automatic logic [MA_W-1:0] exp_col(logic [ADDR_W-1:0] w);
    return MA_W'(w >> 1);
  endfunction

  task automatic check(logic ok, string rq, longint act, longint exp, int cyc);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", rq, cyc, act, exp);
    end
  endtask

  task automatic access(logic fast, logic [ADDR_W-1:0] w, logic wr, logic instr,
                        logic [3:0] be, int n);
    int s;
    s = strobe_cycle(fast);
    @(posedge clk); #1;
    cfg_fast = fast; req = 1'b1; req_addr = w; req_wr = wr;
    req_instr = instr; req_be = be; burst_req = 1'b0;
    @(posedge clk); #1;
    req = 1'b0; req_addr = ADDR_W'($urandom); req_wr = ~wr;
    req_instr = ~instr; req_be = ~be;
    for (int c = 1; c <= s + n + 2; c++) begin
      logic exp_rdy, ras_low, strobing, bk, reading, rbk;
      logic [ADDR_W-1:0] wa, wr_word;
      logic [3:0] ea, eb;
      string lat_tag;
      @(negedge clk);
      lat_tag  = (n > 1) ? "R7" : (fast ? "R2" : "R3");
      exp_rdy  = (c >= s + 1) && (c <= s + n);
      ras_low  = (c >= 1) && (c <= s + n - 1);
      strobing = (c >= s) && (c < s + n);
      wa = w + ADDR_W'(c - s);
      bk = wa[0];
      ea = (strobing && !bk) ? ~be : 4'hF;
      eb = (strobing && bk)  ? ~be : 4'hF;
      check(rdy == exp_rdy, lat_tag, rdy, exp_rdy, c);
      check({ras_n_a, ras_n_b} == {2{!ras_low}}, "R4", {ras_n_a, ras_n_b},
            {2{!ras_low}}, c);
      check({cas_n_a, cas_n_b} == {ea, eb}, (n > 1) ? "R7" : "R6",
            {cas_n_a, cas_n_b}, {ea, eb}, c);
      if (c == 1)
        check(ma_a == exp_row(w) && ma_b == exp_row(w), "R8", {ma_a, ma_b},
              {exp_row(w), exp_row(w)}, c);
      if (strobing)
        check((bk ? ma_b : ma_a) == exp_col(wa), "R8", bk ? ma_b : ma_a,
              exp_col(wa), c);
      check({we_n_a, we_n_b} == {2{!(wr && ras_low)}}, "R9",
            {we_n_a, we_n_b}, {2{!(wr && ras_low)}}, c);
      check({wr_latch_a, wr_latch_b} == {wr && strobing && !bk, wr && strobing && bk},
            "R9", {wr_latch_a, wr_latch_b},
            {wr && strobing && !bk, wr && strobing && bk}, c);
      wr_word = w + ADDR_W'(c - s - 1);
      rbk     = wr_word[0];
      reading = !wr && exp_rdy;
      check({dbus_oe_n_a, dbus_oe_n_b, ibus_oe_n_a, ibus_oe_n_b} ==
            {!(reading && !instr && !rbk), !(reading && !instr && rbk),
             !(reading && instr && !rbk), !(reading && instr && rbk)}, "R10",
            {dbus_oe_n_a, dbus_oe_n_b, ibus_oe_n_a, ibus_oe_n_b},
            {!(reading && !instr && !rbk), !(reading && !instr && rbk),
             !(reading && instr && !rbk), !(reading && instr && rbk)}, c);
      burst_req = (c >= s) && (c <= s + n - 2);
    end
    burst_req = 1'b0;
  endtask

  task automatic back_to_back(logic fast, logic [ADDR_W-1:0] w1,
                              logic [ADDR_W-1:0] w2, logic [3:0] be2);
    int s, first_rdy, second_rdy, hi_run, min_gap;
    logic seen_low;
    s = strobe_cycle(fast);
    first_rdy = -1; second_rdy = -1; hi_run = 0; min_gap = 99; seen_low = 1'b0;
    @(posedge clk); #1;
    cfg_fast = fast; req = 1'b1; req_addr = w1; req_wr = 1'b0;
    req_instr = 1'b0; req_be = 4'hF; burst_req = 1'b0;
    @(posedge clk); #1;
    req_addr = w2; req_be = be2;
    @(posedge clk); #1;
    req = 1'b0; req_addr = '0;
    for (int c = 2; c <= 2 * s + 8; c++) begin
      @(negedge clk);
      if (rdy) begin
        if (first_rdy < 0) first_rdy = c;
        else if (second_rdy < 0) second_rdy = c;
      end
      if (!ras_n_a) begin
        if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        seen_low = 1'b1; hi_run = 0;
      end else hi_run++;
      if (c == 2 * s + 2) begin
        logic [3:0] ea, eb;
        ea = w2[0] ? 4'hF : ~be2;
        eb = w2[0] ? ~be2 : 4'hF;
        check({cas_n_a, cas_n_b} == {ea, eb}, "R5", {cas_n_a, cas_n_b},
              {ea, eb}, c);
      end
    end
    check(first_rdy == s + 1, fast ? "R2" : "R3", first_rdy, s + 1, 0);
    check(second_rdy == first_rdy + s + 2, "R5", second_rdy, first_rdy + s + 2, 0);
    check(min_gap == 2, "R4", min_gap, 2, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0bdc));
    repeat (3) @(negedge clk);
    check({rdy, ras_n_a, ras_n_b, cas_n_a, cas_n_b, we_n_a, we_n_b} ==
          {1'b0, 2'b11, 8'hFF, 2'b11}, "R1",
          {rdy, ras_n_a, ras_n_b, cas_n_a, cas_n_b, we_n_a, we_n_b},
          {1'b0, 2'b11, 8'hFF, 2'b11}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({rdy, wr_latch_a, wr_latch_b, dbus_oe_n_a, dbus_oe_n_b,
           ibus_oe_n_a, ibus_oe_n_b, ras_n_a, cas_n_b} ==
          {3'b000, 4'hF, 1'b1, 4'hF}, "R1",
          {rdy, wr_latch_a, wr_latch_b, dbus_oe_n_a, dbus_oe_n_b,
           ibus_oe_n_a, ibus_oe_n_b, ras_n_a, cas_n_b},
          {3'b000, 4'hF, 1'b1, 4'hF}, 0);

    // Directed corners.
    access(1'b1, 23'h12_3456, 1'b0, 1'b0, 4'hF, 1);   // R2 even, data read
    access(1'b0, 23'h0A_BCD7, 1'b1, 1'b0, 4'h5, 1);   // R3 odd, write
    access(1'b1, 23'h00_0001, 1'b0, 1'b1, 4'hF, 1);   // R10 instruction fetch
    access(1'b1, 23'h04_0010, 1'b0, 1'b0, 4'hF, 4);   // R7 burst from bank A
    access(1'b0, 23'h04_0FFF, 1'b0, 1'b1, 4'hF, 4);   // R7 burst from bank B, column wrap
    access(1'b1, 23'h7F_FFFE, 1'b1, 1'b0, 4'hC, 5);   // R7 write burst
    back_to_back(1'b1, 23'h01_0000, 23'h02_0003, 4'h3); // R4 R5 fast
    back_to_back(1'b0, 23'h03_0005, 23'h05_0008, 4'h9); // R4 R5 slow

    // Constrained random accesses.
    for (int i = 0; i < 40; i++) begin
      logic [3:0] be;
      be = 4'($urandom);
      if (be == 4'h0) be = 4'hF;
      access(1'($urandom), ADDR_W'($urandom), 1'($urandom), 1'($urandom), be,
             1 + int'($urandom % 6));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule